// File: doc/BRIEF.md
# Thermal Zone and Line-Driver Shutdown Manager

This block watches a stream of digitised junction-temperature readings and does two jobs with them. It reports which of four temperature zones the die is in. It also controls the enable of the line-driver amplifier. Each reading arrives as a signed whole-degree value together with a valid strobe. The reading is compared against four programmable thresholds, which the host supplies as one packed vector in ascending order. Typical values are 70, 100, 125 and 170 degrees C.

Zone reporting uses the lower three thresholds. The amplifier is switched off as soon as a reading exceeds the fourth threshold. It is switched back on only once a reading has come down to the third threshold or below, so shutdown and recovery have a wide hysteresis band between them. Entry into shutdown raises a one-cycle event pulse. It also sets a status bit that stays set until the host clears it.

Top module: `thermal_guard`

## Requirements
- R1: While reset is active and afterwards until the first valid sample, zoneCode is 0, driverEnable is 1, shutdownPulse is 0 and shutdownSticky is 0.
- R2: zoneCode reports the zone of the last valid sample, where threshold k (k = 1..4) sits in threshVec bits [k*TEMP_W-1 : (k-1)*TEMP_W] and all values are signed two's complement. Code 0 means the sample is not above threshold 1, code 1 means above threshold 1 but not above threshold 2, code 2 means above threshold 2 but not above threshold 3, and code 3 means above threshold 3.
- R3: A sample exactly equal to a threshold counts as below it, for zone reporting, for the shutdown decision and for the recovery decision.
- R4: All outputs change only in the clock cycle after a sample with sampleValid high. A sample presented with sampleValid low has no effect on any output.
- R5: While the driver is enabled, a valid sample above threshold 4 drives driverEnable low one clock later.
- R6: While the driver is disabled, valid samples above threshold 3 keep it disabled. A valid sample at or below threshold 3 sets driverEnable high one clock later.
- R7: shutdownPulse is high for exactly one cycle, in the cycle in which driverEnable first goes low. Further hot samples during shutdown produce no pulse.
- R8: shutdownSticky goes high together with shutdownPulse and stays high until a cycle with stickyClear high. If a shutdown entry and stickyClear happen in the same cycle, the bit ends up set.
- R9: Zone reporting continues unchanged while the driver is shut down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Qualifies sampleTemp for one cycle |
| sampleTemp | input | TEMP_W | Signed temperature reading in whole degrees C |
| threshVec | input | 4*TEMP_W | Four signed thresholds, threshold 1 in the lowest slice |
| stickyClear | input | 1 | Clears the sticky shutdown status |
| zoneCode | output | 2 | Zone of the last valid sample, 0..3 for zones 1..4 |
| driverEnable | output | 1 | Line-driver enable |
| shutdownPulse | output | 1 | One-cycle pulse on entry into shutdown |
| shutdownSticky | output | 1 | Shutdown-seen status, held until cleared |

## Verification
The bench places samples exactly on each threshold. A design that used greater-or-equal compares would report the higher zone there, would trip at 170 and would fail to recover at 125. It holds a hot reading on the inputs with the strobe low, which catches a design that samples without the qualifier. It sends repeated hot samples during shutdown and readings between the third and fourth thresholds, which expose a second event pulse or an early re-enable such as a design that recovers against the trip threshold. It also makes a shutdown coincide with a sticky clear, where a design that gives the clear priority would lose the event. Long random runs, including negative readings, catch signed-compare mistakes.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;
  localparam int LEVELS = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic zoneLoad;
  } ctl_strobe_t;

  // Comparison results from datapath to control
  typedef struct packed {
    logic overTrip;    // sample above threshold 4
    logic recoverOk;   // sample at or below threshold 3
  } temp_flags_t;

  typedef enum logic {
    ST_RUN = 1'b0,
    ST_OFF = 1'b1
  } guard_state_t;
endpackage

// File: rtl/thermal_guard_datapath.sv
module thermal_guard_datapath
  import thermal_guard_pkg::*;
#(
  parameter int TEMP_W = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [TEMP_W-1:0]        sampleTemp,
  input  logic [LEVELS*TEMP_W-1:0] threshVec,
  input  ctl_strobe_t              strobes,
  output temp_flags_t              flags,
  output logic [1:0]               zoneCode
);
  localparam int ZONE_LEVELS = LEVELS - 1;

  logic [LEVELS-1:0] aboveLvl;
  logic [1:0]        zoneNext;
  logic [1:0]        zoneQ;

  // One signed comparator per threshold; equality counts as below
  for (genvar k = 0; k < LEVELS; k++) begin : g_cmp
    assign aboveLvl[k] = $signed(sampleTemp) > $signed(threshVec[k*TEMP_W +: TEMP_W]);
  end

  always_comb begin
    zoneNext = 2'd0;
    for (int k = 0; k < ZONE_LEVELS; k++) begin
      if (aboveLvl[k]) zoneNext = 2'(k + 1);
    end
  end

  assign flags.overTrip  = aboveLvl[LEVELS-1];
  assign flags.recoverOk = !aboveLvl[LEVELS-2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 zoneQ <= 2'd0;
    else if (strobes.zoneLoad) zoneQ <= zoneNext;
  end

  assign zoneCode = zoneQ;
endmodule

// File: rtl/thermal_guard_ctrl.sv
module thermal_guard_ctrl
  import thermal_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic        stickyClear,
  input  temp_flags_t flags,
  output ctl_strobe_t strobes,
  output logic        driverEnable,
  output logic        shutdownPulse,
  output logic        shutdownSticky
);
  guard_state_t stateQ, stateNext;
  logic         pulseNext;
  logic         pulseQ;
  logic         stickyQ;

  assign strobes.zoneLoad = sampleValid;

  always_comb begin
    stateNext = stateQ;
    pulseNext = 1'b0;
    if (sampleValid) begin
      unique case (stateQ)
        ST_RUN: if (flags.overTrip) begin
          stateNext = ST_OFF;
          pulseNext = 1'b1;
        end
        ST_OFF: if (flags.recoverOk) stateNext = ST_RUN;
        default: stateNext = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_RUN;
      pulseQ  <= 1'b0;
      stickyQ <= 1'b0;
    end else begin
      stateQ <= stateNext;
      pulseQ <= pulseNext;
      if (pulseNext)       stickyQ <= 1'b1;
      else if (stickyClear) stickyQ <= 1'b0;
    end
  end

  assign driverEnable   = (stateQ == ST_RUN);
  assign shutdownPulse  = pulseQ;
  assign shutdownSticky = stickyQ;
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import thermal_guard_pkg::*;
#(
  parameter int TEMP_W = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic [TEMP_W-1:0]        sampleTemp,
  input  logic [LEVELS*TEMP_W-1:0] threshVec,
  input  logic                     stickyClear,
  output logic [1:0]               zoneCode,
  output logic                     driverEnable,
  output logic                     shutdownPulse,
  output logic                     shutdownSticky
);
  ctl_strobe_t strobes;
  temp_flags_t flags;

  thermal_guard_datapath #(.TEMP_W(TEMP_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTemp (sampleTemp),
    .threshVec  (threshVec),
    .strobes    (strobes),
    .flags      (flags),
    .zoneCode   (zoneCode)
  );

  thermal_guard_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .sampleValid    (sampleValid),
    .stickyClear    (stickyClear),
    .flags          (flags),
    .strobes        (strobes),
    .driverEnable   (driverEnable),
    .shutdownPulse  (shutdownPulse),
    .shutdownSticky (shutdownSticky)
  );
endmodule

// File: rtl/thermal_guard_checker.sv
module thermal_guard_checker #(
  parameter int TEMP_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic [TEMP_W-1:0] sampleTemp,
  input logic [4*TEMP_W-1:0] threshVec,
  input logic              stickyClear,
  input logic [1:0]        zoneCode,
  input logic              driverEnable,
  input logic              shutdownPulse,
  input logic              shutdownSticky
);
  logic hotNow;
  assign hotNow = $signed(sampleTemp) > $signed(threshVec[4*TEMP_W-1 -: TEMP_W]);

  AST_ZONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(zoneCode)); // R4
  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(driverEnable)); // R4
  AST_TRIP_HOT: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && driverEnable && hotNow) |=> !driverEnable); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    shutdownPulse |=> !shutdownPulse); // R7
  AST_PULSE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    shutdownPulse |-> (!driverEnable && $past(driverEnable))); // R7
  AST_STICKY_WITH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    shutdownPulse |-> shutdownSticky); // R8
endmodule

bind thermal_guard thermal_guard_checker #(.TEMP_W(TEMP_W)) chk (
  .clk            (clk),
  .rstN           (rstN),
  .sampleValid    (sampleValid),
  .sampleTemp     (sampleTemp),
  .threshVec      (threshVec),
  .stickyClear    (stickyClear),
  .zoneCode       (zoneCode),
  .driverEnable   (driverEnable),
  .shutdownPulse  (shutdownPulse),
  .shutdownSticky (shutdownSticky)
);

// File: tb/thermal_guard_test.sv
module thermal_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 9;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleValid = 1'b0;
  logic [TW-1:0] sampleTemp = '0;
  logic [4*TW-1:0] threshVec;
  logic          stickyClear = 1'b0;
  logic [1:0]    zoneCode;
  logic          driverEnable, shutdownPulse, shutdownSticky;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model state
  int mZone = 0;
  bit mEn = 1, mPulse = 0, mSticky = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign threshVec = {9'(170), 9'(125), 9'(100), 9'(70)};

  thermal_guard #(.TEMP_W(TW)) uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleTemp(sampleTemp),
    .threshVec(threshVec), .stickyClear(stickyClear), .zoneCode(zoneCode),
    .driverEnable(driverEnable), .shutdownPulse(shutdownPulse),
    .shutdownSticky(shutdownSticky));

  function automatic int expZone(int t);
    if (t > 125) return 3;
    if (t > 100) return 2;
    if (t > 70)  return 1;
    return 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string tag);
    check({tag, " zone"}, int'(zoneCode), mZone);
    check({tag, " enable"}, int'(driverEnable), int'(mEn));
    check({tag, " pulse"}, int'(shutdownPulse), int'(mPulse));
    check({tag, " sticky"}, int'(shutdownSticky), int'(mSticky));
  endtask

  // drive at negedge, clock, update model, check at next negedge
  task automatic step(input bit v, input int t, input bit clr, input string tag);
    sampleValid = v;
    sampleTemp  = TW'(t);
    stickyClear = clr;
    @(posedge clk);
    mPulse = 0;
    if (v) begin
      mZone = expZone(t);
      if (mEn && t > 170) begin
        mEn = 0;
        mPulse = 1;
      end else if (!mEn && t <= 125) begin
        mEn = 1;
      end
    end
    if (mPulse) mSticky = 1;
    else if (clr) mSticky = 0;
    @(negedge clk);
    checkAll(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    checkAll("R1 in reset");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after reset");

    step(1, 20, 0, "R2 cool");
    step(1, 70, 0, "R3 equal t1");
    step(1, 71, 0, "R2 zone2");
    step(1, 100, 0, "R3 equal t2");
    step(1, 101, 0, "R2 zone3");
    step(1, 125, 0, "R3 equal t3");
    step(1, 126, 0, "R2 zone4");
    step(0, 200, 0, "R4 invalid hot");
    step(0, -30, 1, "R4 invalid cold");
    step(1, 170, 0, "R3 equal t4 no trip");
    step(1, 171, 0, "R5 trip");
    step(1, 200, 0, "R7 no second pulse");
    step(1, 130, 0, "R6 still off");
    step(1, 160, 0, "R9 zone during off");
    step(1, 125, 0, "R6 recover at t3");
    step(0, 0, 1, "R8 clear");
    step(1, 180, 1, "R8 set wins");
    step(1, -50, 0, "R6 recover negative");
    step(1, -256, 0, "R2 most negative");

    for (int i = 0; i < 3000; i++) begin
      int t;
      bit v, c;
      t = int'($urandom_range(0, 300)) - 60;
      v = ($urandom_range(0, 3) != 0);
      c = ($urandom_range(0, 7) == 0);
      step(v, t, c, "R2 R5 R6 R8 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule